// File: doc/BRIEF.md
# Memory-Mapped Iterative Integer Divider

This block is a 32-bit integer divide unit that a processor reaches through a simple single-cycle register bus. Software stores a dividend, then writes a divisor. The divisor write starts the operation. Writing through the signed divisor address gives a signed division, and writing through the unsigned one gives an unsigned division. Quotient and remainder appear in their result registers a fixed number of cycles later. The bus never waits, so software counts cycles or polls the ready flag before it reads the results.

The operand and result registers can all be read and written directly. An interrupt handler that needs the unit saves the operands and results and puts them back when it is done. Writing a result register loads that value and marks the result ready at once, with no new computation. A dirty flag tells software that a result is waiting that nobody has consumed yet. Reading the quotient consumes it, so software reads the quotient last.

Top module: `mmio_divider`

## Requirements
- R1: A write to the unsigned divisor word (address 1) or the signed divisor word (address 3) starts a division: the ready flag reads 0 on the next cycle. A write to either dividend word (address 0 or 2) only stores the value and leaves ready and the results unchanged.
- R2: The status word (address 6) carries ready in bit 0. Ready becomes 1 exactly 8 clock edges after the divisor write edge, together with the final quotient (address 4) and remainder (address 5). After 7 edges it still reads 0.
- R3: An unsigned division gives the truncated 32-bit quotient and the remainder of the stored dividend by the written divisor.
- R4: A division started through address 3 treats both operands as two's complement. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: Division by zero still completes in 8 cycles, and the remainder equals the dividend. The quotient is 0xFFFFFFFF when unsigned; when signed it is 0xFFFFFFFF for a non-negative dividend and 1 for a negative one.
- R6: The dividend and divisor read back their last written values at any time, including during a division. The signed and unsigned addresses of each operand read the same value.
- R7: A write to the quotient or remainder word loads that value, sets ready on the next cycle and cancels any division in progress, so a later completion does not overwrite it.
- R8: Status bit 1 is the dirty flag. It is set when a division completes or a result word is written, and cleared by a read of the quotient word.
- R9: A divisor write while a division is running restarts it with the new operands, and the full 8-cycle latency counts from the new write.
- R10: After reset all registers read 0, and ready and dirty are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
The assertions assume that the bus carries at most one access per cycle and that bus_wr is meaningful only while bus_sel is high. They also assume that a result write and a divisor write never fall on the same edge, which a single-access bus guarantees. The stimulus drives every access from tasks that raise bus_sel for exactly one cycle, and it changes the bus only at the falling clock edge. Results are read only after the 8-cycle latency, except in tests that aim to cancel or restart a division.

// File: rtl/div_pkg.sv
// Package div_pkg: shared register addresses and status bit positions for
// the memory-mapped divider. Assumes a 3-bit word address bus.
package div_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_UDVD = 3'd0,
        REG_UDVS = 3'd1,
        REG_SDVD = 3'd2,
        REG_SDVS = 3'd3,
        REG_QUO  = 3'd4,
        REG_REM  = 3'd5,
        REG_STAT = 3'd6
    } div_reg_e;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_DIRTY_BIT = 1;
endpackage

// File: rtl/div_bit_stage.sv
// Module div_bit_stage: one restoring-division step that produces a single
// quotient bit. It shifts the next dividend bit into the partial remainder
// and subtracts the divisor when that fits. Assumes rem_in < den, or
// den == 0, so the partial remainder always fits in W bits.
module div_bit_stage #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] den,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] q_out
);
    logic [W:0] shifted;
    logic [W:0] diff;

    // Shift one dividend bit in, then try to subtract the divisor.
    always_comb begin
        shifted = {rem_in, q_in[W-1]};
        diff    = shifted - {1'b0, den};
        if (shifted >= {1'b0, den}) begin
            rem_out = diff[W-1:0];
            q_out   = {q_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            q_out   = {q_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/div_sign_prep.sv
// Module div_sign_prep: turns two operands into unsigned magnitudes and
// works out the signs of quotient and remainder. Assumes two's complement
// operands. In unsigned mode it passes the operands through unchanged.
module div_sign_prep #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] mag_num,
    output logic [W-1:0] mag_den,
    output logic         neg_quo,
    output logic         neg_rem
);
    logic num_neg;
    logic den_neg;

    // Find the operand signs and take absolute values when they are negative.
    always_comb begin
        num_neg = is_signed & num[W-1];
        den_neg = is_signed & den[W-1];
        mag_num = num_neg ? (~num + 1'b1) : num;
        mag_den = den_neg ? (~den + 1'b1) : den;
        neg_quo = num_neg ^ den_neg;
        neg_rem = num_neg;
    end
endmodule

// File: rtl/div_core.sv
// Module div_core: iterative divider that produces RB quotient bits per
// cycle, so a W-bit division takes W/RB cycles. It latches the operand
// magnitudes on start and raises done, with sign-corrected results, on
// its last step. Assumes W is a multiple of RB. start and abort never
// arrive in the same cycle.
module div_core #(
    parameter int W  = 32,
    parameter int RB = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         is_signed,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);
    localparam int STEPS = W / RB;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [W-1:0]     part_rem;
    logic [W-1:0]     part_quo;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] step_cnt;
    logic             neg_quo_q;
    logic             neg_rem_q;

    logic [W-1:0] mag_num;
    logic [W-1:0] mag_den;
    logic         neg_quo;
    logic         neg_rem;

    div_sign_prep #(.W(W)) u_prep (
        .is_signed (is_signed),
        .num       (num),
        .den       (den),
        .mag_num   (mag_num),
        .mag_den   (mag_den),
        .neg_quo   (neg_quo),
        .neg_rem   (neg_rem)
    );

    // Chain of RB single-bit stages evaluated within one cycle.
    logic [W-1:0] rem_c [RB+1];
    logic [W-1:0] quo_c [RB+1];

    assign rem_c[0] = part_rem;
    assign quo_c[0] = part_quo;

    for (genvar g = 0; g < RB; g++) begin : g_stage
        div_bit_stage #(.W(W)) u_bit (
            .rem_in  (rem_c[g]),
            .q_in    (quo_c[g]),
            .den     (den_q),
            .rem_out (rem_c[g+1]),
            .q_out   (quo_c[g+1])
        );
    end

    assign done = busy && (step_cnt == CNT_W'(STEPS - 1));

    // Apply the result signs to the outputs of the last step.
    always_comb begin
        quo_out = neg_quo_q ? (~quo_c[RB] + 1'b1) : quo_c[RB];
        rem_out = neg_rem_q ? (~rem_c[RB] + 1'b1) : rem_c[RB];
    end

    // Load operands on start, advance one radix step per cycle while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            step_cnt  <= '0;
            part_rem  <= '0;
            part_quo  <= '0;
            den_q     <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
        end else if (abort) begin
            busy     <= 1'b0;
            step_cnt <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            step_cnt  <= '0;
            part_rem  <= '0;
            part_quo  <= mag_num;
            den_q     <= mag_den;
            neg_quo_q <= neg_quo;
            neg_rem_q <= neg_rem;
        end else if (busy) begin
            part_rem <= rem_c[RB];
            part_quo <= quo_c[RB];
            if (done) begin
                busy     <= 1'b0;
                step_cnt <= '0;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start && !abort) |=> !busy);                       // R2
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (busy && step_cnt == '0));             // R9
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);                                            // R7
endmodule

// File: rtl/mmio_divider.sv
// Module mmio_divider: register file for the bus-attached 32-bit divider.
// A divisor write launches div_core, and the signedness comes from the
// address used. Results land in the quotient and remainder registers with
// the ready and dirty flags. Result registers can be written to restore a
// saved context. Assumes one single-cycle access per clock and no stalls.
module mmio_divider
    import div_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RADIX_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int STEPS = DATA_W / RADIX_BITS;
    localparam int LAT_W = $clog2(STEPS + 2) + 1;

    logic [DATA_W-1:0] dvd_q;
    logic [DATA_W-1:0] dvs_q;
    logic [DATA_W-1:0] quo_q;
    logic [DATA_W-1:0] rem_q;
    logic              ready_q;
    logic              dirty_q;

    logic wr_en;
    logic rd_en;
    logic wr_dvd;
    logic wr_dvs;
    logic wr_signed;
    logic wr_quo;
    logic wr_rem;
    logic wr_result;
    logic rd_quo;

    logic              core_busy;
    logic              core_done;
    logic [DATA_W-1:0] core_quo;
    logic [DATA_W-1:0] core_rem;

    // Decode the bus access into per-register strobes.
    always_comb begin
        wr_en     = bus_sel & bus_wr;
        rd_en     = bus_sel & ~bus_wr;
        wr_dvd    = wr_en & ((bus_addr == REG_UDVD) | (bus_addr == REG_SDVD));
        wr_dvs    = wr_en & ((bus_addr == REG_UDVS) | (bus_addr == REG_SDVS));
        wr_signed = (bus_addr == REG_SDVS);
        wr_quo    = wr_en & (bus_addr == REG_QUO);
        wr_rem    = wr_en & (bus_addr == REG_REM);
        wr_result = wr_quo | wr_rem;
        rd_quo    = rd_en & (bus_addr == REG_QUO);
    end

    div_core #(.W(DATA_W), .RB(RADIX_BITS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_dvs),
        .abort     (wr_result),
        .is_signed (wr_signed),
        .num       (dvd_q),
        .den       (bus_wdata),
        .busy      (core_busy),
        .done      (core_done),
        .quo_out   (core_quo),
        .rem_out   (core_rem)
    );

    // Hold the operand registers; either alias writes the same storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
        end else begin
            if (wr_dvd) dvd_q <= bus_wdata;
            if (wr_dvs) dvs_q <= bus_wdata;
        end
    end

    // Load results from the core on completion or from the bus on restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
        end else if (wr_result) begin
            if (wr_quo) quo_q <= bus_wdata;
            if (wr_rem) rem_q <= bus_wdata;
        end else if (core_done && !wr_dvs) begin
            quo_q <= core_quo;
            rem_q <= core_rem;
        end
    end

    // Track ready: cleared by a start, set by completion or a restore.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ready_q <= 1'b0;
        else if (wr_result)             ready_q <= 1'b1;
        else if (wr_dvs)                ready_q <= 1'b0;
        else if (core_done)             ready_q <= 1'b1;
    end

    // Track dirty: set when a result appears, cleared by a quotient read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dirty_q <= 1'b0;
        else if (wr_result)                  dirty_q <= 1'b1;
        else if (core_done && !wr_dvs)       dirty_q <= 1'b1;
        else if (rd_quo)                     dirty_q <= 1'b0;
    end

    // Drive read data from the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_UDVD, REG_SDVD: bus_rdata = dvd_q;
            REG_UDVS, REG_SDVS: bus_rdata = dvs_q;
            REG_QUO:            bus_rdata = quo_q;
            REG_REM:            bus_rdata = rem_q;
            REG_STAT: begin
                bus_rdata[STAT_READY_BIT] = ready_q;
                bus_rdata[STAT_DIRTY_BIT] = dirty_q;
            end
            default:            bus_rdata = '0;
        endcase
    end

    // Checker counter: edges since the last start, saturating past the latency.
    logic [LAT_W-1:0] chk_lat;
    always_ff @(posedge clk) begin
        if (!rst_n || wr_result)                    chk_lat <= '0;
        else if (wr_dvs)                            chk_lat <= LAT_W'(1);
        else if (chk_lat != '0 && chk_lat != LAT_W'(STEPS + 1))
                                                    chk_lat <= chk_lat + 1'b1;
    end

    AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dvs && !wr_result) |=> !ready_q);                                  // R1
    AST_DVD_WR_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dvd && !core_done) |=> (ready_q == $past(ready_q)));               // R1
    AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !$past(ready_q) && !$past(wr_result)) |-> (chk_lat == LAT_W'(STEPS + 1))); // R2
    AST_OPERAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dvd && !wr_dvs) |=> ($stable(dvd_q) && $stable(dvs_q)));          // R6
    AST_RESTORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_result |=> (ready_q && dirty_q));                                   // R7
    AST_QREAD_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_quo && !core_done) |=> !dirty_q);                                  // R8
    AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dvs && core_busy) |=> (core_busy && !ready_q));                    // R9
endmodule

// File: tb/mmio_divider_tb.sv
`timescale 1ns/1ps
module mmio_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    mmio_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #10 clk = ~clk;

    localparam logic [2:0] A_UDVD = 3'd0, A_UDVS = 3'd1, A_SDVD = 3'd2,
                           A_SDVS = 3'd3, A_QUO = 3'd4, A_REM = 3'd5, A_STAT = 3'd6;

    // {signed, dividend, divisor, quotient, remainder}
    localparam int NV = 13;
    localparam logic [128:0] VECS [NV] = '{
        {1'b0, 32'd100,        32'd7,          32'd14,         32'd2},
        {1'b0, 32'hFFFF_FFFF,  32'd1,          32'hFFFF_FFFF,  32'd0},
        {1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd1,          32'd0},
        {1'b0, 32'd5,          32'd10,         32'd0,          32'd5},
        {1'b0, 32'h8000_0000,  32'd3,          32'h2AAA_AAAA,  32'd2},
        {1'b0, 32'hDEAD_BEEF,  32'h10,         32'h0DEA_DBEE,  32'hF},
        {1'b1, 32'hFFFF_FFF9,  32'd2,          32'hFFFF_FFFD,  32'hFFFF_FFFF},
        {1'b1, 32'd7,          32'hFFFF_FFFE,  32'hFFFF_FFFD,  32'd1},
        {1'b1, 32'hFFFF_FFF9,  32'hFFFF_FFFE,  32'd3,          32'hFFFF_FFFF},
        {1'b1, 32'h8000_0000,  32'hFFFF_FFFF,  32'h8000_0000,  32'd0},
        {1'b0, 32'd1234,       32'd0,          32'hFFFF_FFFF,  32'd1234},
        {1'b1, 32'hFFFF_FFFB,  32'd0,          32'd1,          32'hFFFF_FFFB},
        {1'b1, 32'd5,          32'd0,          32'hFFFF_FFFF,  32'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; the write lands on the rising edge between.
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Samples combinational read data, then lets one edge pass.
    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        bus_read(A_STAT, rd); chk("R10 status", rd, 32'd0);
        bus_read(A_REM,  rd); chk("R10 remainder", rd, 32'd0);
        bus_read(A_UDVD, rd); chk("R10 dividend", rd, 32'd0);
        bus_read(A_QUO,  rd); chk("R10 quotient", rd, 32'd0);

        // R3 R4 R5 R8: vector table
        for (int i = 0; i < NV; i++) begin
            logic sgn;
            sgn = VECS[i][128];
            bus_write(sgn ? A_SDVD : A_UDVD, VECS[i][127:96]);
            bus_write(sgn ? A_SDVS : A_UDVS, VECS[i][95:64]);
            repeat (8) @(negedge clk);
            bus_read(A_STAT, rd); chk("R8 ready+dirty", rd, 32'd3);
            bus_read(A_REM, rd);  chk(sgn ? "R4 R5 remainder" : "R3 R5 remainder", rd, VECS[i][31:0]);
            bus_read(A_QUO, rd);  chk(sgn ? "R4 R5 quotient" : "R3 R5 quotient", rd, VECS[i][63:32]);
            bus_read(A_STAT, rd); chk("R8 dirty cleared", rd, 32'd1);
        end

        // R1: a dividend write alone changes nothing but the dividend
        bus_write(A_UDVD, 32'd60);
        bus_read(A_STAT, rd); chk("R1 dividend write keeps ready", rd, 32'd1);
        bus_read(A_QUO, rd);  chk("R1 dividend write keeps quotient", rd, 32'hFFFF_FFFF);

        // R1 R2 R6: latency edge and readback during busy
        bus_write(A_UDVS, 32'd7);
        bus_read(A_STAT, rd); chk("R1 ready low after start", rd, 32'd0);
        bus_read(A_SDVD, rd); chk("R6 dividend during busy", rd, 32'd60);
        bus_read(A_SDVS, rd); chk("R6 divisor alias", rd, 32'd7);
        repeat (4) @(negedge clk);
        bus_read(A_STAT, rd); chk("R2 not ready after 7", rd, 32'd0);
        bus_read(A_STAT, rd); chk("R2 ready after 8", rd, 32'd3);
        bus_read(A_REM, rd);  chk("R2 remainder", rd, 32'd4);
        bus_read(A_QUO, rd);  chk("R2 quotient", rd, 32'd8);

        // R9: restart mid-operation
        bus_write(A_UDVD, 32'd100);
        bus_write(A_UDVS, 32'd3);
        repeat (3) @(negedge clk);
        bus_write(A_UDVS, 32'd5);
        repeat (7) @(negedge clk);
        bus_read(A_STAT, rd); chk("R9 not ready 7 after restart", rd, 32'd0);
        bus_read(A_STAT, rd); chk("R9 ready 8 after restart", rd, 32'd3);
        bus_read(A_QUO, rd);  chk("R9 restarted quotient", rd, 32'd20);

        // R7: restore cancels a running division
        bus_write(A_UDVS, 32'd9);
        bus_write(A_QUO, 32'h1111_2222);
        bus_read(A_STAT, rd); chk("R7 ready after quotient write", rd, 32'd3);
        bus_write(A_REM, 32'h33);
        repeat (12) @(negedge clk);
        bus_read(A_REM, rd);  chk("R7 remainder kept", rd, 32'h33);
        bus_read(A_QUO, rd);  chk("R7 quotient kept", rd, 32'h1111_2222);
        bus_read(A_STAT, rd); chk("R8 dirty cleared after restore", rd, 32'd1);

        // R7 R8: a remainder write alone sets ready and dirty
        bus_write(A_REM, 32'h44);
        bus_read(A_STAT, rd); chk("R8 dirty after remainder write", rd, 32'd3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule